// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Controller

This block gathers single-cycle event pulses from a radio peripheral into a set of 8-bit interrupt status registers. It drives one active-low interrupt request pin that a host loops back to one of its own external interrupt inputs. Each event line has an enable bit. An event whose enable bit is clear never reaches its status bit. An enabled event sets its status bit, and that bit stays set until the host reads the status register that holds it.

The host uses a small register interface with an address, a read strobe, a write strobe and write data. Read data is registered and appears after the clock edge that samples the strobe. A status read returns the latched bits and clears them at that same edge. An event pulse in the cycle of the read is kept, and it shows up on the following read. The request pin is registered. It stays low while any status bit is set. It returns high at the edge that clears the last set bit, and it goes low again only when a new enabled event arrives.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset all status and enable bits are zero, `irq_n_o` is 1 and `bus_rdata_o` is 0.
- R2: An enabled pulse on `evt_i[k*8+j]` sets bit j of status register k. Register 0 is at address 03h and register 1 at 04h. `irq_n_o` is 0 after the clock edge that samples the pulse.
- R3: A pulse on an event line whose enable bit is 0 sets no status bit and leaves `irq_n_o` at 1.
- R4: Enable register k (05h for k=0, 06h for k=1) is readable and writable and resets to zero. Bit j of enable register k gates `evt_i[k*8+j]`.
- R5: A read at a status address puts the latched status on `bus_rdata_o` after the sampling edge. The same edge clears that register to zero.
- R6: An enabled event that arrives in the cycle of a status read is not part of that read's data. It is returned by the next read of that register.
- R7: `irq_n_o` goes to 1 only at the edge of a status read that leaves every status register empty. It stays 0 while another register still holds a set bit.
- R8: After release, `irq_n_o` stays 1 through idle cycles and goes to 0 again on the next enabled event.
- R9: Set status bits accumulate across separate events until they are read.
- R10: A read at an unmapped address returns 0. A write to a status address has no effect.
- R11: Clearing an enable bit does not clear a status bit that is already latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 16 | Single-cycle event pulses, bit k*8+j feeds status register k bit j |
| bus_addr_i | input | 8 | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions run on every cycle and check the behaviour seen at the ports. A falling edge on the request pin must follow an enabled event, computed from a shadow copy of the enables. A rising edge must follow a status read. Read data must hold between reads. Unmapped reads must return zero, and enable reads must return the shadowed value. Some properties depend on the exact status contents, and only the directed scenarios can show them. These are the accumulation of bits, a coincident event surviving a read, the pin staying low while the second register is still unread, masking, and latched bits surviving an enable being cleared.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_STAT = 2'd1,
    ACC_EN   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n_o = sync_q[1];
endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_REGS  = 2,
  parameter int STAT_BASE = 3,
  parameter int EN_BASE   = 5,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    kind_o = ACC_NONE;
    idx_o  = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (addr_i == ADDR_W'(STAT_BASE + k)) begin
        kind_o = ACC_STAT;
        idx_o  = IDX_W'(k);
      end
      if (addr_i == ADDR_W'(EN_BASE + k)) begin
        kind_o = ACC_EN;
        idx_o  = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         pend_nx_o
);
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] en_q, en_d;

  // next state: clear-on-read first, then new enabled events are merged in
  always_comb begin
    en_d   = en_wdata_i;
    stat_d = (rd_clr_i ? '0 : stat_q) | (evt_i & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      if (en_we_i) en_q <= en_d;
    end
  end

  assign stat_o    = stat_q;
  assign en_o      = en_q;
  assign pend_nx_o = |stat_d;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_REGS  = 2,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int STAT_BASE = 3,
  parameter int EN_BASE   = 5,
  localparam int EVT_W    = NUM_REGS * DATA_W,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_n_o
);
  logic              srst_n;
  acc_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] stat_arr [NUM_REGS];
  logic [DATA_W-1:0] en_arr   [NUM_REGS];
  logic [NUM_REGS-1:0] pend_nx;
  logic [NUM_REGS-1:0] clr_sel, we_sel;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              irq_n_d, irq_n_q;

  irq_rst_sync u_rst (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  irq_addr_dec #(
    .ADDR_W    (ADDR_W),
    .NUM_REGS  (NUM_REGS),
    .STAT_BASE (STAT_BASE),
    .EN_BASE   (EN_BASE)
  ) u_dec (
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .idx_o  (idx)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_bank
    assign clr_sel[k] = bus_rd_i && (kind == ACC_STAT) && (idx == IDX_W'(k));
    assign we_sel[k]  = bus_wr_i && (kind == ACC_EN)   && (idx == IDX_W'(k));

    irq_stat_bank #(.W(DATA_W)) u_bank (
      .clk        (clk),
      .rst_n      (srst_n),
      .evt_i      (evt_i[k*DATA_W +: DATA_W]),
      .en_we_i    (we_sel[k]),
      .en_wdata_i (bus_wdata_i),
      .rd_clr_i   (clr_sel[k]),
      .stat_o     (stat_arr[k]),
      .en_o       (en_arr[k]),
      .pend_nx_o  (pend_nx[k])
    );
  end

  // read mux and request next state
  always_comb begin
    rdata_d = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (idx == IDX_W'(k)) begin
        if (kind == ACC_STAT) rdata_d = stat_arr[k];
        if (kind == ACC_EN)   rdata_d = en_arr[k];
      end
    end
    irq_n_d = ~(|pend_nx);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
      irq_n_q <= 1'b1;
    end else begin
      if (bus_rd_i) rdata_q <= rdata_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_n_o     = irq_n_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int NUM_REGS  = 2,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int STAT_BASE = 3,
  parameter int EN_BASE   = 5,
  localparam int EVT_W    = NUM_REGS * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EVT_W-1:0]  evt_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_n_o
);
  logic [EVT_W-1:0]  en_sh;
  logic              rd_stat, rd_en, rd_unmapped, evt_hit;
  logic [DATA_W-1:0] en_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_sh <= '0;
    else begin
      for (int k = 0; k < NUM_REGS; k++)
        if (bus_wr_i && (int'(bus_addr_i) == EN_BASE + k))
          en_sh[k*DATA_W +: DATA_W] <= bus_wdata_i;
    end
  end

  always_comb begin
    rd_stat = 1'b0;
    rd_en   = 1'b0;
    en_sel  = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (int'(bus_addr_i) == STAT_BASE + k) rd_stat = bus_rd_i;
      if (int'(bus_addr_i) == EN_BASE + k) begin
        rd_en  = bus_rd_i;
        en_sel = en_sh[k*DATA_W +: DATA_W];
      end
    end
    rd_unmapped = bus_rd_i && !rd_stat && !rd_en;
    evt_hit     = |(evt_i & en_sh);
  end

  a_r2_event_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> !irq_n_o);

  a_r3_fall_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> $past(evt_hit));

  a_r7_rise_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |-> $past(rd_stat));

  a_r4_enable_readback: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (bus_rdata_o == $past(en_sel)));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (bus_rdata_o == '0));

  a_r5_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

bind irq_status_ctrl irq_status_chk #(
  .NUM_REGS  (NUM_REGS),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .STAT_BASE (STAT_BASE),
  .EN_BASE   (EN_BASE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_n_o     (irq_n_o)
);

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt;
  logic [7:0]  addr;
  logic        rd, wr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq_n;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_status_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .bus_addr_i  (addr),
    .bus_rd_i    (rd),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_n_o     (irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg_evt(input logic [7:0] a, input logic [15:0] e, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; evt = e;
    @(negedge clk); rd = 1'b0; evt = '0; d = rdata;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    rd_reg_evt(a, 16'h0000, d);
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 irq_n", {15'd0, irq_n}, 16'h0001);
    chk("R1 rdata", {8'd0, rdata}, 16'h0000);
    rd_reg(8'h05, d); chk("R1 en0", {8'd0, d}, 16'h0000);
    rd_reg(8'h06, d); chk("R1 en1", {8'd0, d}, 16'h0000);
    rd_reg(8'h03, d); chk("R1 stat0", {8'd0, d}, 16'h0000);
  endtask

  task automatic t_enable_rw;
    logic [7:0] d;
    wr_reg(8'h05, 8'hA5); rd_reg(8'h05, d); chk("R4 en0 rw", {8'd0, d}, 16'h00A5);
    wr_reg(8'h06, 8'h3C); rd_reg(8'h06, d); chk("R4 en1 rw", {8'd0, d}, 16'h003C);
    wr_reg(8'h05, 8'hFF); wr_reg(8'h06, 8'hFF);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    pulse(16'h0008);
    wr_reg(8'h03, 8'hFF);
    rd_reg(8'h10, d); chk("R10 unmapped read", {8'd0, d}, 16'h0000);
    rd_reg(8'h03, d); chk("R10 status write ignored", {8'd0, d}, 16'h0008);
  endtask

  task automatic t_masked;
    logic [7:0] d;
    wr_reg(8'h05, 8'hFE);
    pulse(16'h0001);
    chk("R3 irq stays high", {15'd0, irq_n}, 16'h0001);
    rd_reg(8'h03, d); chk("R3 masked bit clear", {8'd0, d}, 16'h0000);
    wr_reg(8'h05, 8'hFF);
  endtask

  task automatic t_single;
    logic [7:0] d;
    pulse(16'h0004);
    chk("R2 irq low", {15'd0, irq_n}, 16'h0000);
    rd_reg(8'h03, d);
    chk("R5 read data", {8'd0, d}, 16'h0004);
    chk("R7 released", {15'd0, irq_n}, 16'h0001);
    rd_reg(8'h03, d); chk("R5 cleared", {8'd0, d}, 16'h0000);
  endtask

  task automatic t_accumulate;
    logic [7:0] d;
    pulse(16'h0001);
    repeat (2) @(negedge clk);
    pulse(16'h0081);
    rd_reg(8'h03, d); chk("R9 accumulate", {8'd0, d}, 16'h0081);
  endtask

  task automatic t_coincident;
    logic [7:0] d;
    pulse(16'h0001);
    rd_reg_evt(8'h03, 16'h0002, d);
    chk("R6 current read", {8'd0, d}, 16'h0001);
    chk("R6 irq still low", {15'd0, irq_n}, 16'h0000);
    rd_reg(8'h03, d);
    chk("R6 kept event", {8'd0, d}, 16'h0002);
    chk("R6 irq released", {15'd0, irq_n}, 16'h0001);
  endtask

  task automatic t_two_regs;
    logic [7:0] d;
    pulse(16'h0110);
    rd_reg(8'h04, d); chk("R2 reg1 data", {8'd0, d}, 16'h0001);
    chk("R7 other reg pending", {15'd0, irq_n}, 16'h0000);
    rd_reg(8'h03, d); chk("R2 reg0 data", {8'd0, d}, 16'h0010);
    chk("R7 all read", {15'd0, irq_n}, 16'h0001);
  endtask

  task automatic t_rearm;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R8 idle stays high", {15'd0, irq_n}, 16'h0001);
    pulse(16'h8000);
    chk("R8 re-assert", {15'd0, irq_n}, 16'h0000);
    rd_reg(8'h04, d); chk("R8 data", {8'd0, d}, 16'h0080);
  endtask

  task automatic t_disable_keeps;
    logic [7:0] d;
    pulse(16'h0200);
    wr_reg(8'h06, 8'h00);
    chk("R11 irq held", {15'd0, irq_n}, 16'h0000);
    rd_reg(8'h04, d); chk("R11 bit kept", {8'd0, d}, 16'h0002);
    pulse(16'h0200);
    chk("R4 gated irq", {15'd0, irq_n}, 16'h0001);
    rd_reg(8'h04, d); chk("R4 gated bit", {8'd0, d}, 16'h0000);
    wr_reg(8'h06, 8'hFF);
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable_rw();
    t_unmapped();
    t_masked();
    t_single();
    t_accumulate();
    t_coincident();
    t_two_regs();
    t_rearm();
    t_disable_keeps();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule